// File: doc/BRIEF.md
# Secured Boundary-Scan Test Port Controller

This block is the serial test port of a programmable device. A four-wire serial interface (clock, mode select, data in, data out) steers a sixteen-state controller. That controller picks either the instruction register or one of several data registers and places it between the serial input and the serial output. The data registers are a one-bit bypass stage, a fixed 32-bit identification word, a boundary chain around every user pin, a 16-bit user signature, and a small register array that stands in for the device's configuration store.

A security-fuse input stops the configuration store from being read back. Scans still write it, but every readback shows zeros. The user signature is not affected by the fuse and can always be written and read. User pins go to high impedance in three cases: while the configuration store is selected (programming in progress), while the programming-hold input reports an interrupted cycle, and while the HIGHZ instruction is loaded.

The interface is bit-serial with no valid/ready handshake. Every rising edge of the test clock moves one bit, and the controller cannot apply back-pressure. The data input is sampled on the rising edge, and the data output changes only on the falling edge.

Top module: `scan_port_ctrl`

## Requirements
- R1: On power-on reset, and after five consecutive rising test-clock edges with the mode input high, the controller is in its reset state with the identification instruction loaded. The data output enable is low.
- R2: The instruction register is 4 bits wide and is shifted LSB first. It captures 4'b0001, so the first two bits out are 1 then 0. The codes are 0x0 boundary drive (EXTEST), 0x1 sample/preload, 0x2 identification, 0x3 HIGHZ, 0x8 user signature, 0x9 configuration access and 0xF bypass. Any other code selects the bypass stage.
- R3: The identification register captures the parameter word (default 0x1A5E303F, LSB = 1) and shifts it out LSB first.
- R4: The bypass stage captures 0 and delays the serial input by exactly one shift.
- R5: The boundary chain has 2*NPINS bits. Bits [NPINS-1:0] are per-pin data cells, which capture the pin inputs. Bits [2*NPINS-1:NPINS] are per-pin enable cells, which capture the core output enables. Bit 0 is nearest the serial output. The update cells load from the chain when a scan ends under sample/preload or boundary drive.
- R6: Under boundary drive, the pad outputs and enables come from the update cells.
- R7: Under HIGHZ, every pad enable is 0 and the selected data register is the bypass stage.
- R8: Under the user-signature code, a scan captures the stored 16-bit signature and writes the shifted-in word back when the scan ends, whatever the fuse input is.
- R9: Under configuration access, a scan captures the CFG_BITS store when the fuse is clear and all zeros when it is set. The shifted-in word is written to the store in both cases.
- R10: Every pad enable is 0 while configuration access is loaded or while the programming-hold input is high.
- R11: The serial output changes only on falling test-clock edges. Its enable is high exactly in the two shift states.
- R12: Under every other instruction, and with the programming-hold input low, the pads carry the core outputs and core enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_oe | output | 1 | Serial data out enable |
| sec_fuse | input | 1 | Security fuse state, 1 = readback locked |
| prog_hold | input | 1 | Programming in progress or interrupted |
| pin_in | input | NPINS | Values seen at the pins |
| core_out | input | NPINS | Functional output data from the core |
| core_oe | input | NPINS | Functional output enables from the core |
| pad_out | output | NPINS | Data to the pad drivers |
| pad_oe | output | NPINS | Enables to the pad drivers |

## Verification
The hardest case to reach from the ports is a locked readback of a store that holds a known non-zero word. To reach it, the stimulus writes the store while the fuse is clear, reads it back once to prove the contents, then raises the fuse and scans again so that only zeros come out. A final scan with the fuse cleared shows that the locked scan still wrote the store. Boundary drive is reached in a similar way: the update cells are preloaded under sample/preload, and the instruction is then switched, so the pads change only on that instruction change.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [2:0] {DR_BYP, DR_ID, DR_BSC, DR_SIG, DR_CFG} dr_sel_t;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OP_EXTEST  = 4'h0;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'h1;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'h2;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'h3;
  localparam logic [IR_W-1:0] OP_USERSIG = 4'h8;
  localparam logic [IR_W-1:0] OP_CFG     = 4'h9;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_TLR;
    else        state <= nxt;
  end
endmodule

// File: rtl/shift_dr.sv
// Capture/shift register with parallel view; shifts toward bit 0.
module shift_dr #(
  parameter int W = 16
) (
  input  logic         tck,
  input  logic         por_n,
  input  logic         cap_en,
  input  logic         sh_en,
  input  logic [W-1:0] cap_val,
  input  logic         tdi,
  output logic [W-1:0] q
);
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)      q <= '0;
    else if (cap_en) q <= cap_val;
    else if (sh_en)  q <= {tdi, q[W-1:1]};
  end
endmodule

// File: rtl/const_dr.sv
// Fixed-capture register exposing only its serial output.
module const_dr #(
  parameter int         W   = 32,
  parameter logic [W-1:0] CAP = '0
) (
  input  logic tck,
  input  logic por_n,
  input  logic cap_en,
  input  logic sh_en,
  input  logic tdi,
  output logic so
);
  if (W == 1) begin : g_single
    logic r;
    always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)      r <= 1'b0;
      else if (cap_en) r <= CAP[0];
      else if (sh_en)  r <= tdi;
    end
    assign so = r;
  end else begin : g_multi
    logic [W-1:0] r;
    always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)      r <= '0;
      else if (cap_en) r <= CAP;
      else if (sh_en)  r <= {tdi, r[W-1:1]};
    end
    assign so = r[0];
  end
endmodule

// File: rtl/bscan_cells.sv
// Per-pin data and enable cells: capture chain plus update stage.
module bscan_cells #(
  parameter int N = 8
) (
  input  logic         tck,
  input  logic         por_n,
  input  logic         cap_en,
  input  logic         sh_en,
  input  logic         upd_en,
  input  logic         tdi,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] core_oe,
  output logic         so,
  output logic [N-1:0] upd_out,
  output logic [N-1:0] upd_oe
);
  localparam int L = 2 * N;
  logic [L-1:0] chain;

  shift_dr #(.W(L)) u_chain (
    .tck(tck), .por_n(por_n), .cap_en(cap_en), .sh_en(sh_en),
    .cap_val({core_oe, pin_in}), .tdi(tdi), .q(chain)
  );

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      upd_out <= '0;
      upd_oe  <= '0;
    end else if (upd_en) begin
      upd_out <= chain[N-1:0];
      upd_oe  <= chain[L-1:N];
    end
  end

  assign so = chain[0];
endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_pkg::*;
#(
  parameter int          NPINS      = 8,
  parameter int          CFG_BITS   = 16,
  parameter int          SIG_BITS   = 16,
  parameter logic [31:0] IDCODE_VAL = 32'h1A5E_303F
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic             sec_fuse,
  input  logic             prog_hold,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  tap_state_t       state;
  logic [IR_W-1:0]  ir_q, instr;
  dr_sel_t          sel;
  logic             cap_dr, sh_dr, upd_dr;
  logic             byp_so, id_so, bsc_so, dr_lsb, tdo_next;
  logic [SIG_BITS-1:0] sig_q, sig_store;
  logic [CFG_BITS-1:0] cfg_q, cfg_store;
  logic [NPINS-1:0] upd_out, upd_oe;
  logic             hold_z, extest;

  tap_fsm u_fsm (.tck(tck), .por_n(por_n), .tms(tms), .state(state));

  assign cap_dr = (state == ST_CAP_DR);
  assign sh_dr  = (state == ST_SH_DR);
  assign upd_dr = (state == ST_UPD_DR);

  // Instruction path
  shift_dr #(.W(IR_W)) u_ir (
    .tck(tck), .por_n(por_n), .cap_en(state == ST_CAP_IR), .sh_en(state == ST_SH_IR),
    .cap_val(IR_CAPTURE), .tdi(tdi), .q(ir_q)
  );

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                 instr <= OP_IDCODE;
    else if (state == ST_TLR)   instr <= OP_IDCODE;
    else if (state == ST_UPD_IR) instr <= ir_q;
  end

  always_comb begin
    unique case (instr)
      OP_EXTEST, OP_SAMPLE: sel = DR_BSC;
      OP_IDCODE:            sel = DR_ID;
      OP_USERSIG:           sel = DR_SIG;
      OP_CFG:               sel = DR_CFG;
      default:              sel = DR_BYP;
    endcase
  end

  // Data registers
  const_dr #(.W(1), .CAP(1'b0)) u_byp (
    .tck(tck), .por_n(por_n), .cap_en(cap_dr && sel == DR_BYP),
    .sh_en(sh_dr && sel == DR_BYP), .tdi(tdi), .so(byp_so)
  );

  const_dr #(.W(32), .CAP(IDCODE_VAL)) u_id (
    .tck(tck), .por_n(por_n), .cap_en(cap_dr && sel == DR_ID),
    .sh_en(sh_dr && sel == DR_ID), .tdi(tdi), .so(id_so)
  );

  bscan_cells #(.N(NPINS)) u_bsc (
    .tck(tck), .por_n(por_n), .cap_en(cap_dr && sel == DR_BSC),
    .sh_en(sh_dr && sel == DR_BSC), .upd_en(upd_dr && sel == DR_BSC),
    .tdi(tdi), .pin_in(pin_in), .core_oe(core_oe), .so(bsc_so),
    .upd_out(upd_out), .upd_oe(upd_oe)
  );

  shift_dr #(.W(SIG_BITS)) u_sig (
    .tck(tck), .por_n(por_n), .cap_en(cap_dr && sel == DR_SIG),
    .sh_en(sh_dr && sel == DR_SIG), .cap_val(sig_store), .tdi(tdi), .q(sig_q)
  );

  // Configuration readback is masked at capture while the fuse is set
  shift_dr #(.W(CFG_BITS)) u_cfg (
    .tck(tck), .por_n(por_n), .cap_en(cap_dr && sel == DR_CFG),
    .sh_en(sh_dr && sel == DR_CFG), .cap_val(sec_fuse ? '0 : cfg_store),
    .tdi(tdi), .q(cfg_q)
  );

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      sig_store <= '0;
      cfg_store <= '0;
    end else if (upd_dr) begin
      if (sel == DR_SIG) sig_store <= sig_q;
      if (sel == DR_CFG) cfg_store <= cfg_q;
    end
  end

  // Serial output, retimed to the falling edge
  always_comb begin
    unique case (sel)
      DR_ID:   dr_lsb = id_so;
      DR_BSC:  dr_lsb = bsc_so;
      DR_SIG:  dr_lsb = sig_q[0];
      DR_CFG:  dr_lsb = cfg_q[0];
      default: dr_lsb = byp_so;
    endcase
    tdo_next = (state == ST_SH_IR) ? ir_q[0] : dr_lsb;
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_next;
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end

  // Pad control: forced high-Z has priority over boundary drive
  assign hold_z  = prog_hold || (instr == OP_HIGHZ) || (instr == OP_CFG);
  assign extest  = (instr == OP_EXTEST);
  assign pad_out = extest ? upd_out : core_out;
  assign pad_oe  = hold_z ? '0 : (extest ? upd_oe : core_oe);
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int CFG_BITS = 16,
  parameter int SIG_BITS = 16
) (
  input logic                tck,
  input logic                por_n,
  input logic                tms,
  input logic [3:0]          st,
  input logic [IR_W-1:0]     instr,
  input logic                sec_fuse,
  input logic                prog_hold,
  input logic                tdo_oe,
  input logic [NPINS-1:0]    pad_oe,
  input logic [SIG_BITS-1:0] sig_q,
  input logic [SIG_BITS-1:0] sig_store,
  input logic [CFG_BITS-1:0] cfg_q
);
  assert_reset_idcode_R1: assert property (@(posedge tck) disable iff (!por_n)
    (st == ST_TLR) |=> (instr == OP_IDCODE));

  assert_tms_reset_R1: assert property (@(posedge tck) disable iff (!por_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (st == ST_TLR));

  assert_highz_R7: assert property (@(posedge tck) disable iff (!por_n)
    (instr == OP_HIGHZ) |-> (pad_oe == '0));

  assert_hold_R10: assert property (@(posedge tck) disable iff (!por_n)
    (prog_hold || instr == OP_CFG) |-> (pad_oe == '0));

  assert_fuse_mask_R9: assert property (@(posedge tck) disable iff (!por_n)
    (st == ST_CAP_DR && instr == OP_CFG && sec_fuse) |=> (cfg_q == '0));

  assert_sig_write_R8: assert property (@(posedge tck) disable iff (!por_n)
    (st == ST_UPD_DR && instr == OP_USERSIG) |=> (sig_store == $past(sig_q)));

  assert_tdo_oe_R11: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == (st == ST_SH_DR || st == ST_SH_IR));
endmodule

bind scan_port_ctrl scan_port_chk #(.NPINS(NPINS), .CFG_BITS(CFG_BITS), .SIG_BITS(SIG_BITS)) u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .st(state), .instr(instr), .sec_fuse(sec_fuse),
  .prog_hold(prog_hold), .tdo_oe(tdo_oe), .pad_oe(pad_oe), .sig_q(sig_q),
  .sig_store(sig_store), .cfg_q(cfg_q)
);

// File: tb/scan_port_ctrl_bench.sv
`timescale 1ns/1ps
module scan_port_ctrl_bench;
  localparam int N = 8;
  localparam logic [31:0] ID = 32'h1A5E_303F;

  logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic sec_fuse = 1'b0, prog_hold = 1'b0;
  logic [N-1:0] pin_in = '0, core_out = '0, core_oe = '0;
  logic tdo, tdo_oe;
  logic [N-1:0] pad_out, pad_oe;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 tck = ~tck;

  scan_port_ctrl u_scan_port_ctrl (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .sec_fuse(sec_fuse), .prog_hold(prog_hold), .pin_in(pin_in), .core_out(core_out),
    .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Drive after falling edge, sample tdo there, then wait past rising edge
  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    #2;
    o   = tdo;
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
    logic x;
    step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < 4; i++) step(i == 3, op[i], cap[i]);
    step(1, 0, x); step(0, 0, x);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic x;
    logic edge_ok = 1'b1;
    dout = '0;
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], dout[i]);
      if (tdo !== dout[i] || tdo_oe !== 1'b1) edge_ok = 1'b0;
    end
    step(1, 0, x); step(0, 0, x);
    chk("R11 tdo held across rising edge", {63'd0, edge_ok}, 64'd1);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    repeat (3) @(posedge tck);
    @(negedge tck); por_n = 1'b1;
    core_out = 8'h96; core_oe = 8'hA5;
    @(negedge tck); #2;
    chk("R1 tdo_oe low after reset", {63'd0, tdo_oe}, 64'd0);
    chk("R12 functional pads after reset", {48'd0, pad_oe, pad_out}, {48'd0, 8'hA5, 8'h96});
    step(0, 0, d[0]);
    scan_dr(32, 64'd0, d);
    chk("R3 idcode after power-on R1", d, {32'd0, ID});
  endtask

  task automatic t_bypass();
    logic [3:0] cap;
    logic [63:0] d;
    load_ir(4'hF, cap);
    chk("R2 IR capture pattern", {60'd0, cap[1:0] == 2'b01, 3'd0}, 64'd8);
    scan_dr(8, 64'hB6, d);
    chk("R4 bypass one-bit delay", d, 64'h6C);
    load_ir(4'h6, cap);
    scan_dr(8, 64'h5B, d);
    chk("R2 unlisted code selects bypass", d, 64'hB6);
  endtask

  task automatic t_boundary();
    logic [3:0] cap;
    logic [63:0] d;
    pin_in = 8'h3C; core_oe = 8'hA5; core_out = 8'h96;
    load_ir(4'h1, cap);
    scan_dr(16, 64'hF05A, d);
    chk("R5 sample captures enables and pins", d, 64'hA53C);
    chk("R12 pads functional under sample", {48'd0, pad_oe, pad_out}, {48'd0, 8'hA5, 8'h96});
    load_ir(4'h0, cap);
    chk("R6 extest drives preloaded cells", {48'd0, pad_oe, pad_out}, {48'd0, 8'hF0, 8'h5A});
    pin_in = 8'h81;
    scan_dr(16, 64'h0FC3, d);
    chk("R5 extest capture", d, 64'hA581);
    chk("R6 extest drives updated cells", {48'd0, pad_oe, pad_out}, {48'd0, 8'h0F, 8'hC3});
  endtask

  task automatic t_highz();
    logic [3:0] cap;
    logic [63:0] d;
    load_ir(4'h3, cap);
    chk("R7 highz disables pads", {56'd0, pad_oe}, 64'd0);
    scan_dr(4, 64'hD, d);
    chk("R7 highz uses bypass", d, 64'hA);
  endtask

  task automatic t_usersig();
    logic [3:0] cap;
    logic [63:0] d;
    sec_fuse = 1'b1;
    load_ir(4'h8, cap);
    scan_dr(16, 64'hA5C3, d);
    chk("R8 signature initial zero", d, 64'h0);
    scan_dr(16, 64'h0, d);
    chk("R8 signature readable with fuse set", d, 64'hA5C3);
    sec_fuse = 1'b0;
  endtask

  task automatic t_cfg();
    logic [3:0] cap;
    logic [63:0] d;
    load_ir(4'h9, cap);
    chk("R10 pads high-Z under config access", {56'd0, pad_oe}, 64'd0);
    scan_dr(16, 64'h3E91, d);
    scan_dr(16, 64'h3E91, d);
    chk("R9 config readback with fuse clear", d, 64'h3E91);
    sec_fuse = 1'b1;
    scan_dr(16, 64'h7C24, d);
    chk("R9 config readback masked by fuse", d, 64'h0);
    sec_fuse = 1'b0;
    scan_dr(16, 64'h0, d);
    chk("R9 locked scan still wrote store", d, 64'h7C24);
  endtask

  task automatic t_hold_and_reset();
    logic [3:0] cap;
    logic [63:0] d;
    logic x;
    load_ir(4'h1, cap);
    core_oe = 8'h5F;
    prog_hold = 1'b1;
    #3;
    chk("R10 programming hold forces high-Z", {56'd0, pad_oe}, 64'd0);
    prog_hold = 1'b0;
    #3;
    chk("R12 pads return after hold", {56'd0, pad_oe}, {56'd0, 8'h5F});
    for (int i = 0; i < 5; i++) step(1, 0, x);
    chk("R1 tdo_oe low after tms reset", {63'd0, tdo_oe}, 64'd0);
    step(0, 0, x);
    scan_dr(32, 64'd0, d);
    chk("R1 idcode after five tms highs", d, {32'd0, ID});
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_boundary();
    t_highz();
    t_usersig();
    t_cfg();
    t_hold_and_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R1 act=hung exp=complete");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule